// File: doc/BRIEF.md
# Daisy-Chain Serial Potentiometer Master

This block is the host side of a serial link to a chain of digital potentiometer devices. Each device holds six 8-bit wiper slots, and the devices are wired output to input. The master drives an enable line, a serial clock and a data line. It can write one full frame of wiper data to every device in the chain in one transaction. It can also read the chain back. In a read the master stops driving the data line, so the chain's feedback path returns the last device's output to the first device's input. The frame then circulates once around the loop. The master captures the frame as it passes and the devices end up holding what they held before.

All serial timing comes from the system clock. Five programmable cycle counts set the timing: the lead time from enable to the first rising edge, the clock high time, the clock low time, the tail time after the last high phase, and the minimum enable-low gap between transactions. A count of zero selects a default. The default is the shortest whole number of system cycles that meets that interval at the system clock frequency set by `SYS_MHZ`. The timing inputs must be held steady while `busy` is high. A command is taken only while the master is idle. `done` pulses once the enable-low gap has elapsed, and a read result is then presented on `rd_data`.

Top module: `pot_chain_master`

## Requirements
- R1: Synchronous reset forces `sp_en`, `sp_clk`, `sp_oe`, `busy` and `done` low and clears `rd_data` to zero.
- R2: Every transaction produces exactly FRAME = 48·N_DEV rising edges of `sp_clk`, and `sp_clk` is high only while `sp_en` is high.
- R3: In a write, bit i of `cmd_data` is on `sp_dout` throughout the i-th high phase of `sp_clk` (bit 0 first). It was set when the previous low phase began, or when `sp_en` rose for bit 0, and `sp_dout` never changes while `sp_clk` is high.
- R4: Let the accept edge be the clock edge at which `cmd_valid` is taken. Counted from that edge, `sp_en` is high with `sp_clk` low for t_lead cycles. Then come FRAME high phases of t_high cycles, separated by low phases of t_low cycles. Then come t_tail cycles with `sp_clk` low and `sp_en` high, then t_gap cycles with `sp_en` low.
- R5: A timing input of zero selects ceil(ns·SYS_MHZ/1000) cycles, with a minimum of 1. The intervals are 50 ns for lead, high, low and tail, and 125 ns for the gap. At SYS_MHZ = 100 these are 5, 5, 5, 5 and 13.
- R6: In a read, `sp_oe` stays low. `sp_din` is sampled in the cycle before each rising edge of `sp_clk`, and `rd_data[i]` holds the i-th sample. `rd_data` updates when `sp_en` falls, so a loop with feedback returns the stored frame unchanged.
- R7: In a write, `sp_oe` is high for exactly the cycles in which `sp_en` is high.
- R8: `busy` is high from the cycle after the accept edge until the gap ends. `done` is then high for one cycle with `busy` low, and a command offered in that cycle is accepted.
- R9: `cmd_valid` while `busy` is high is ignored: the current transaction runs unchanged and no second one follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| srst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request, taken when idle |
| cmd_read | input | 1 | 1 = read (circulate), 0 = write |
| cmd_data | input | FRAME | Write frame, bit 0 shifted first |
| t_lead | input | CNT_W | Enable-to-first-rise cycles (0 = default) |
| t_high | input | CNT_W | Serial clock high cycles (0 = default) |
| t_low | input | CNT_W | Serial clock low cycles (0 = default) |
| t_tail | input | CNT_W | Cycles after last high phase before enable drops (0 = default) |
| t_gap | input | CNT_W | Enable-low cycles before done (0 = default) |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | FRAME | Frame captured by the last read |
| sp_en | output | 1 | Serial enable to the chain |
| sp_clk | output | 1 | Serial clock to the chain |
| sp_oe | output | 1 | Drive enable for the data line |
| sp_dout | output | 1 | Serial data toward the first device |
| sp_din | input | 1 | Data line as seen through the feedback path |

## Verification
The pin waveform is fixed by the timing counts. Counting from the accept edge, every pin's level in cycle t follows from t_lead, t_high, t_low, t_tail and t_gap. The bench's reference model therefore computes the expected `sp_en`, `sp_clk`, `sp_oe`, `sp_dout`, `busy` and `done` from that cycle index and compares them with the design each cycle, at the falling edge. The model takes a command at the same rising edge as the design. It expects `done` in cycle t_lead+(FRAME-1)(t_high+t_low)+t_high+t_tail+t_gap+1. `rd_data` and the state of the modelled device chain are checked in the `done` cycle, after `rd_data` has been loaded at the fall of `sp_en`.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

    // Transaction phases of the serial sequencer.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEAD,
        PH_HIGH,
        PH_LOW,
        PH_TAIL,
        PH_GAP
    } phase_e;

    // Registered serial pin bundle.
    typedef struct packed {
        logic en;
        logic clk;
        logic oe;
        logic dout;
    } pins_t;

    // Index of each programmable interval.
    localparam int TI_LEAD = 0;
    localparam int TI_HIGH = 1;
    localparam int TI_LOW  = 2;
    localparam int TI_TAIL = 3;
    localparam int TI_GAP  = 4;
    localparam int TI_NUM  = 5;

    // Minimum duration of each interval in nanoseconds.
    function automatic int unsigned interval_ns(int idx);
        return (idx == TI_GAP) ? 125 : 50;
    endfunction

    // Smallest cycle count covering ns at mhz, never below one.
    function automatic int unsigned ns_to_cycles(int unsigned ns, int unsigned mhz);
        int unsigned c;
        c = (ns * mhz + 999) / 1000;
        return (c == 0) ? 1 : c;
    endfunction

endpackage

// File: rtl/pcm_timer.sv
module pcm_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             srst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    // A load of V makes expired rise V-1 cycles later, so a phase lasts V cycles.
    always_ff @(posedge clk) begin
        if (srst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val - CNT_W'(1);
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/pcm_shift.sv
module pcm_shift #(
    parameter int W = 96
) (
    input  logic         clk,
    input  logic         srst,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         step,
    input  logic         sin,
    input  logic         capture,
    output logic         head,
    output logic [W-1:0] captured
);
    logic [W-1:0] sh;

    // One register serves both directions: bits leave at the bottom,
    // samples enter at the top, so after W steps sample i sits at bit i.
    always_ff @(posedge clk) begin
        if (srst) begin
            sh <= '0;
        end else if (load) begin
            sh <= load_data;
        end else if (step) begin
            sh <= {sin, sh[W-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (srst) begin
            captured <= '0;
        end else if (capture) begin
            captured <= sh;
        end
    end

    assign head = sh[0];
endmodule

// File: rtl/pot_chain_master.sv
module pot_chain_master
    import pcm_pkg::*;
#(
    parameter int N_DEV      = 2,
    parameter int CH_PER_DEV = 6,
    parameter int CH_BITS    = 8,
    parameter int SYS_MHZ    = 100,
    parameter int CNT_W      = 8,
    localparam int FRAME     = N_DEV * CH_PER_DEV * CH_BITS
) (
    input  logic             clk,
    input  logic             srst,
    input  logic             cmd_valid,
    input  logic             cmd_read,
    input  logic [FRAME-1:0] cmd_data,
    input  logic [CNT_W-1:0] t_lead,
    input  logic [CNT_W-1:0] t_high,
    input  logic [CNT_W-1:0] t_low,
    input  logic [CNT_W-1:0] t_tail,
    input  logic [CNT_W-1:0] t_gap,
    output logic             busy,
    output logic             done,
    output logic [FRAME-1:0] rd_data,
    output logic             sp_en,
    output logic             sp_clk,
    output logic             sp_oe,
    output logic             sp_dout,
    input  logic             sp_din
);
    localparam int BW = $clog2(FRAME);

    phase_e          ph;
    pins_t           pins;
    logic            is_read;
    logic [BW-1:0]   bits_left;
    logic            tmr_load, tmr_exp;
    logic [CNT_W-1:0] tmr_val;
    logic            sh_load, sh_step, sh_cap, sh_head;

    // Effective interval counts: zero on an input picks the derived default.
    logic [CNT_W-1:0] t_req [TI_NUM];
    logic [CNT_W-1:0] t_eff [TI_NUM];

    assign t_req[TI_LEAD] = t_lead;
    assign t_req[TI_HIGH] = t_high;
    assign t_req[TI_LOW]  = t_low;
    assign t_req[TI_TAIL] = t_tail;
    assign t_req[TI_GAP]  = t_gap;

    for (genvar gi = 0; gi < TI_NUM; gi++) begin : g_tdef
        localparam logic [CNT_W-1:0] DEF = CNT_W'(ns_to_cycles(interval_ns(gi), SYS_MHZ));
        assign t_eff[gi] = (t_req[gi] == '0) ? DEF : t_req[gi];
    end

    // Phase-exit controls for timer and shifter.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = t_eff[TI_LEAD];
        sh_load  = 1'b0;
        sh_step  = 1'b0;
        sh_cap   = 1'b0;
        unique case (ph)
            PH_IDLE: begin
                if (cmd_valid) begin
                    tmr_load = 1'b1;
                    sh_load  = 1'b1;
                end
            end
            PH_LEAD, PH_LOW: begin
                if (tmr_exp) begin
                    tmr_load = 1'b1;
                    tmr_val  = t_eff[TI_HIGH];
                    sh_step  = 1'b1;
                end
            end
            PH_HIGH: begin
                if (tmr_exp) begin
                    tmr_load = 1'b1;
                    tmr_val  = (bits_left == '0) ? t_eff[TI_TAIL] : t_eff[TI_LOW];
                end
            end
            PH_TAIL: begin
                if (tmr_exp) begin
                    tmr_load = 1'b1;
                    tmr_val  = t_eff[TI_GAP];
                    sh_cap   = is_read;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (srst) begin
            ph        <= PH_IDLE;
            pins      <= '0;
            is_read   <= 1'b0;
            bits_left <= '0;
            busy      <= 1'b0;
            done      <= 1'b0;
        end else begin
            unique case (ph)
                PH_IDLE: begin
                    done <= 1'b0;
                    if (cmd_valid) begin
                        ph        <= PH_LEAD;
                        busy      <= 1'b1;
                        is_read   <= cmd_read;
                        bits_left <= BW'(FRAME - 1);
                        pins.en   <= 1'b1;
                        pins.oe   <= ~cmd_read;
                        pins.dout <= cmd_data[0];
                    end
                end
                PH_LEAD, PH_LOW: begin
                    if (tmr_exp) begin
                        ph       <= PH_HIGH;
                        pins.clk <= 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (tmr_exp) begin
                        pins.clk <= 1'b0;
                        if (bits_left == '0) begin
                            ph <= PH_TAIL;
                        end else begin
                            ph        <= PH_LOW;
                            bits_left <= bits_left - BW'(1);
                            pins.dout <= sh_head;
                        end
                    end
                end
                PH_TAIL: begin
                    if (tmr_exp) begin
                        ph      <= PH_GAP;
                        pins.en <= 1'b0;
                        pins.oe <= 1'b0;
                    end
                end
                PH_GAP: begin
                    if (tmr_exp) begin
                        ph   <= PH_IDLE;
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    pcm_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .srst     (srst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    pcm_shift #(.W(FRAME)) u_shift (
        .clk       (clk),
        .srst      (srst),
        .load      (sh_load),
        .load_data (cmd_data),
        .step      (sh_step),
        .sin       (sp_din),
        .capture   (sh_cap),
        .head      (sh_head),
        .captured  (rd_data)
    );

    assign sp_en   = pins.en;
    assign sp_clk  = pins.clk;
    assign sp_oe   = pins.oe;
    assign sp_dout = pins.dout;
endmodule

// File: rtl/pcm_checker.sv
module pcm_checker #(
    parameter int FRAME = 96
) (
    input logic clk,
    input logic srst,
    input logic cmd_valid,
    input logic busy,
    input logic done,
    input logic sp_en,
    input logic sp_clk,
    input logic sp_oe,
    input logic sp_dout
);
    localparam int RW = $clog2(FRAME + 1);

    logic [RW-1:0] rises;
    logic          clk_d;

    // Rising edges of the serial clock within the current enable window.
    always_ff @(posedge clk) begin
        if (srst) begin
            rises <= '0;
            clk_d <= 1'b0;
        end else begin
            clk_d <= sp_clk;
            if (!sp_en)
                rises <= '0;
            else if (sp_clk && !clk_d)
                rises <= rises + RW'(1);
        end
    end

    assert_clk_inside_en_R2: assert property (@(posedge clk) disable iff (srst)
        sp_clk |-> sp_en);

    assert_edge_count_R2: assert property (@(posedge clk) disable iff (srst)
        $fell(sp_en) |-> (rises == RW'(FRAME)));

    assert_dout_steady_high_R3: assert property (@(posedge clk) disable iff (srst)
        !$stable(sp_dout) |-> !sp_clk);

    assert_oe_steady_R7: assert property (@(posedge clk) disable iff (srst)
        (sp_en && $past(sp_en)) |-> $stable(sp_oe));

    assert_oe_inside_en_R7: assert property (@(posedge clk) disable iff (srst)
        sp_oe |-> sp_en);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (srst)
        done |=> !done);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (srst)
        done |-> (!busy && !sp_en));

    assert_start_fresh_R9: assert property (@(posedge clk) disable iff (srst)
        $rose(sp_en) |-> ($rose(busy) && $past(cmd_valid)));
endmodule

bind pot_chain_master pcm_checker #(.FRAME(FRAME)) u_chk (
    .clk       (clk),
    .srst      (srst),
    .cmd_valid (cmd_valid),
    .busy      (busy),
    .done      (done),
    .sp_en     (sp_en),
    .sp_clk    (sp_clk),
    .sp_oe     (sp_oe),
    .sp_dout   (sp_dout)
);

// File: tb/pot_chain_master_tb.sv
module pot_chain_master_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N_DEV   = 2;
    localparam int SYS_MHZ = 100;
    localparam int CNT_W   = 8;
    localparam int F       = N_DEV * 48;

    logic           clk = 1'b0;
    logic           srst = 1'b1;
    logic           cmd_valid = 1'b0;
    logic           cmd_read = 1'b0;
    logic [F-1:0]   cmd_data = '0;
    logic [CNT_W-1:0] t_lead = '0, t_high = '0, t_low = '0, t_tail = '0, t_gap = '0;
    logic           busy, done, sp_en, sp_clk, sp_oe, sp_dout, sp_din;
    logic [F-1:0]   rd_data;

    int vecs = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pot_chain_master #(.N_DEV(N_DEV), .SYS_MHZ(SYS_MHZ), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .srst(srst), .cmd_valid(cmd_valid), .cmd_read(cmd_read),
        .cmd_data(cmd_data), .t_lead(t_lead), .t_high(t_high), .t_low(t_low),
        .t_tail(t_tail), .t_gap(t_gap), .busy(busy), .done(done),
        .rd_data(rd_data), .sp_en(sp_en), .sp_clk(sp_clk), .sp_oe(sp_oe),
        .sp_dout(sp_dout), .sp_din(sp_din)
    );

    // Behavioural device chain: one long shift register, fed back when undriven.
    logic [F-1:0] chain = '0;
    int rises = 0;
    always @(posedge sp_clk) begin
        rises++;
        if (sp_en) chain <= {chain[F-2:0], (sp_oe ? sp_dout : chain[F-1])};
    end
    assign sp_din = chain[F-1];

    // Reference model: cycle index since the accept edge.
    bit         m_act = 0, m_done = 0, m_rd = 0, m_def = 0;
    int         m_t = 0, Tl, Th, Tlo, Tt, Tg, L;
    logic [F-1:0] m_data, m_snap;

    function automatic int eff(int v, int ns);
        int c;
        c = (ns * SYS_MHZ + 999) / 1000;
        if (c < 1) c = 1;
        return (v == 0) ? c : v;
    endfunction

    always @(posedge clk) begin
        if (srst) begin
            m_act = 0; m_done = 0;
        end else begin
            m_done = 0;
            if (m_act) begin
                m_t++;
                if (m_t == L + 1) begin m_act = 0; m_done = 1; end
            end else if (cmd_valid) begin
                m_act = 1; m_t = 1;
                m_rd = cmd_read; m_data = cmd_data; m_snap = chain;
                m_def = (t_lead == 0);
                Tl = eff(t_lead, 50); Th = eff(t_high, 50); Tlo = eff(t_low, 50);
                Tt = eff(t_tail, 50); Tg = eff(t_gap, 125);
                L = Tl + (F - 1) * (Th + Tlo) + Th + Tt + Tg;
            end
        end
    end

    task automatic chk(string req, string nm, logic got, logic exp);
        vecs++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s t=%0d got %b exp %b", req, nm, m_t, got, exp);
        end
    endtask

    task automatic chkv(string req, string nm, logic [F-1:0] got, logic [F-1:0] exp);
        vecs++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s got %h exp %h", req, nm, got, exp);
        end
    endtask

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (!srst && !finished) begin
            logic e_en, e_clk, e_dout;
            int u, P;
            string rt;
            rt = m_def ? "R5" : "R4";
            e_en = 0; e_clk = 0; e_dout = 0;
            if (m_act) begin
                P = Th + Tlo;
                e_en = (m_t <= L - Tg);
                if (m_t <= Tl) begin
                    e_dout = m_data[0];
                end else begin
                    u = m_t - Tl - 1;
                    if (u < (F - 1) * P) begin
                        e_clk  = (u % P) < Th;
                        e_dout = e_clk ? m_data[u / P] : m_data[u / P + 1];
                    end else begin
                        e_clk  = (u < (F - 1) * P + Th);
                        e_dout = m_data[F-1];
                    end
                end
            end
            chk(rt, "sp_en", sp_en, e_en);
            chk(rt, "sp_clk", sp_clk, e_clk);
            chk(m_rd ? "R6" : "R7", "sp_oe", sp_oe, e_en && !m_rd);
            if (e_en && !m_rd) chk("R3", "sp_dout", sp_dout, e_dout);
            chk("R8", "busy", busy, m_act);
            chk("R8", "done", done, m_done);
        end
    end

    task automatic run(bit rd, logic [F-1:0] d, int a, int b, int c, int e, int g,
                       bit intrude, logic [F-1:0] d2);
        int r0;
        cmd_read = rd; cmd_data = d;
        t_lead = CNT_W'(a); t_high = CNT_W'(b); t_low = CNT_W'(c);
        t_tail = CNT_W'(e); t_gap = CNT_W'(g);
        cmd_valid = 1'b1;
        r0 = rises;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (intrude) begin
            repeat (10) @(negedge clk);
            cmd_valid = 1'b1; cmd_read = 1'b1; cmd_data = d2;
            repeat (3) @(negedge clk);
            cmd_valid = 1'b0;
        end
        while (!m_done) @(negedge clk);
        chk("R2", "rise_count_ok", (rises - r0) == F, 1'b1);
        if (rd) begin
            logic [F-1:0] ex;
            for (int i = 0; i < F; i++) ex[i] = m_snap[F-1-i];
            chkv("R6", "rd_data", rd_data, ex);
            chkv("R6", "chain_preserved", chain, m_snap);
        end else begin
            logic [F-1:0] got;
            for (int i = 0; i < F; i++) got[i] = chain[F-1-i];
            chkv(intrude ? "R9" : "R3", "chain_written", got, d);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        srst = 1'b0;
        @(negedge clk);
        chk("R1", "reset_en", sp_en, 1'b0);
        chk("R1", "reset_clk", sp_clk, 1'b0);
        chk("R1", "reset_oe", sp_oe, 1'b0);
        chk("R1", "reset_busy", busy, 1'b0);
        chk("R1", "reset_done", done, 1'b0);
        chkv("R1", "reset_rd_data", rd_data, '0);

        run(0, 96'hF0E1_D2C3_B4A5_9687_7869_5A4B, 2, 1, 2, 1, 3, 0, '0);
        run(1, '0, 2, 1, 2, 1, 3, 0, '0);
        run(0, 96'h0123_4567_89AB_CDEF_FEDC_BA98, 0, 0, 0, 0, 0, 0, '0);
        run(1, '1, 0, 0, 0, 0, 0, 0, '0);
        run(0, 96'h8000_0000_0000_0000_0000_0001, 1, 1, 1, 1, 1, 1, 96'hFFFF_0000_FFFF_0000_FFFF_0000);
        run(1, '0, 3, 2, 1, 2, 2, 0, '0);

        repeat (8) @(negedge clk);
        chk("R9", "idle_busy", busy, 1'b0);
        chk("R9", "idle_en", sp_en, 1'b0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end
endmodule